// File: doc/BRIEF.md
# Output Channel Occupancy Load Tracker

This block gives an adaptive router a load estimate for every output channel in a network that has no credit counts, such as one that buffers flits in the channel stages. It holds one occupancy counter per output. The counter estimates how many flits are in flight in a watched stretch of that channel. When a routing decision picks an output, that output's counter goes up by the whole packet length at once. It then goes down by one each time a flit leaves the watched stretch.

Each cycle up to `NUM_DEC` routing requests arrive. Each request carries a set of candidate outputs and a packet length. The block handles the requests in a fixed order, starting with request 0. Each request gets the candidate with the lowest load. That load already counts the lengths granted to earlier requests in the same cycle, so two requests in one cycle do not both pile onto the same idle output without seeing each other. The grants are combinational from the registered counters. The counters update on the next clock edge.

Top module: `occ_tracker`

## Requirements
- R1: While reset is asserted, and until the first update after it is released, every counter on `occ` reads zero.
- R2: A valid request with a non-empty candidate mask is granted the candidate with the smallest load. A tie goes to the lowest-numbered output. `grant_port` slice k (bits `k*PORT_W +: PORT_W`) holds the output index in binary. Candidate bit j of request k is `req_cand[k*NUM_OUT + j]`.
- R3: Requests are handled in ascending index order. The load that request k compares equals the registered count plus the lengths granted to requests 0..k-1 in the same cycle. Flit departures in that cycle are not included.
- R4: With no departure, a granted output's counter rises on the next edge by the sum of the lengths granted to it in that cycle.
- R5: A departure pulse on an output with no grant lowers its counter by one on the next edge.
- R6: A grant and a departure on the same output in one cycle are applied together. The net change is the granted length minus one.
- R7: The counter saturates at 2^CNT_W-1 and stays there while increments continue.
- R8: A departure on a counter at zero with no grant leaves it at zero.
- R9: A request that is not valid, or that has an empty candidate mask, gets no grant and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NUM_DEC | One valid bit per routing request |
| req_cand | input | NUM_DEC*NUM_OUT | Candidate output mask per request |
| req_len | input | NUM_DEC*LEN_W | Packet length in flits per request |
| flit_leave | input | NUM_OUT | Per-output pulse: one flit left the watched segment |
| grant_valid | output | NUM_DEC | A grant was made for the request |
| grant_port | output | NUM_DEC*PORT_W | Chosen output index per request |
| occ | output | NUM_OUT*CNT_W | Occupancy counter per output |

## Verification
The checker watches every cycle that a grant only appears for a valid request and lands inside its candidate mask. It also checks each counter's next value against its previous value, the granted lengths and the departure pulse. That covers increment, decrement, combined update, saturation and the zero floor. What the assertions cannot show is that the grant picks the least-loaded candidate, with ties and in-cycle ordering handled correctly. The bench shows this by comparing every grant against a reference model, using directed ties, same-cycle spreading over idle outputs, and random traffic that drives the counters to both ends of their range.

// File: rtl/occ_pkg.sv
package occ_pkg;
  // Wide accumulator for in-cycle load views; far wider than any counter plus summed lengths.
  typedef logic [31:0] acc_t;
endpackage

// File: rtl/occ_rst_sync.sv
module occ_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/occ_argmin.sv
module occ_argmin import occ_pkg::*; #(
  parameter int NUM_OUT = 5,
  parameter int PORT_W  = 3
) (
  input  acc_t [NUM_OUT-1:0] view,
  input  logic [NUM_OUT-1:0] mask,
  output logic               found,
  output logic [PORT_W-1:0]  idx
);
  acc_t best;

  // Strict less-than keeps the lowest index on ties.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (mask[i] && (!found || view[i] < best)) begin
        found = 1'b1;
        idx   = PORT_W'(i);
        best  = view[i];
      end
    end
  end
endmodule

// File: rtl/occ_dec_stage.sv
module occ_dec_stage import occ_pkg::*; #(
  parameter int NUM_OUT = 5,
  parameter int PORT_W  = 3,
  parameter int LEN_W   = 4
) (
  input  logic               valid,
  input  logic [NUM_OUT-1:0] cand,
  input  logic [LEN_W-1:0]   len,
  input  acc_t [NUM_OUT-1:0] view_in,
  output logic               grant,
  output logic [PORT_W-1:0]  port,
  output acc_t [NUM_OUT-1:0] view_out
);
  logic found;

  occ_argmin #(.NUM_OUT(NUM_OUT), .PORT_W(PORT_W)) u_argmin (
    .view  (view_in),
    .mask  (cand),
    .found (found),
    .idx   (port)
  );

  assign grant = valid && found;

  // The next stage sees this request's length added to the granted output.
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_view
    assign view_out[g] = view_in[g] +
                         ((grant && (port == PORT_W'(g))) ? acc_t'(len) : acc_t'(0));
  end
endmodule

// File: rtl/occ_counter.sv
module occ_counter import occ_pkg::*; #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_t             inc,
  input  logic             leave,
  output logic [CNT_W-1:0] cnt
);
  localparam acc_t CNT_MAX = acc_t'({CNT_W{1'b1}});

  acc_t             sum;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    sum = acc_t'(cnt) + inc;
    if (leave && (sum != '0)) sum = sum - acc_t'(1);
    if (sum > CNT_MAX) cnt_nxt = CNT_MAX[CNT_W-1:0];
    else               cnt_nxt = sum[CNT_W-1:0];
    cnt_en = leave || (inc != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/occ_tracker.sv
module occ_tracker import occ_pkg::*; #(
  parameter int NUM_OUT = 5,
  parameter int NUM_DEC = 3,
  parameter int CNT_W   = 5,
  parameter int LEN_W   = 4,
  parameter int PORT_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_DEC-1:0]          req_valid,
  input  logic [NUM_DEC*NUM_OUT-1:0]  req_cand,
  input  logic [NUM_DEC*LEN_W-1:0]    req_len,
  input  logic [NUM_OUT-1:0]          flit_leave,
  output logic [NUM_DEC-1:0]          grant_valid,
  output logic [NUM_DEC*PORT_W-1:0]   grant_port,
  output logic [NUM_OUT*CNT_W-1:0]    occ
);
  logic                             rst_int_n;
  acc_t [NUM_DEC:0][NUM_OUT-1:0]    view;
  logic [NUM_OUT-1:0][CNT_W-1:0]    cnt;

  occ_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  // Stage 0 starts from the registered counts.
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_seed
    assign view[0][o] = acc_t'(cnt[o]);
  end

  // Requests are chained in port order, so each sees its predecessors' lengths.
  for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
    occ_dec_stage #(.NUM_OUT(NUM_OUT), .PORT_W(PORT_W), .LEN_W(LEN_W)) u_stage (
      .valid    (req_valid[k]),
      .cand     (req_cand[k*NUM_OUT +: NUM_OUT]),
      .len      (req_len[k*LEN_W +: LEN_W]),
      .view_in  (view[k]),
      .grant    (grant_valid[k]),
      .port     (grant_port[k*PORT_W +: PORT_W]),
      .view_out (view[k+1])
    );
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_cnt
    occ_counter #(.CNT_W(CNT_W)) u_counter (
      .clk   (clk),
      .rst_n (rst_int_n),
      .inc   (view[NUM_DEC][o] - view[0][o]),
      .leave (flit_leave[o]),
      .cnt   (cnt[o])
    );
    assign occ[o*CNT_W +: CNT_W] = cnt[o];
  end
endmodule

// File: rtl/occ_tracker_chk.sv
module occ_tracker_chk #(
  parameter int NUM_OUT = 5,
  parameter int NUM_DEC = 3,
  parameter int CNT_W   = 5,
  parameter int LEN_W   = 4,
  parameter int PORT_W  = 3
) (
  input logic                       clk,
  input logic                       rst_int_n,
  input logic [NUM_DEC-1:0]         req_valid,
  input logic [NUM_DEC*NUM_OUT-1:0] req_cand,
  input logic [NUM_DEC*LEN_W-1:0]   req_len,
  input logic [NUM_OUT-1:0]         flit_leave,
  input logic [NUM_DEC-1:0]         grant_valid,
  input logic [NUM_DEC*PORT_W-1:0]  grant_port,
  input logic [NUM_OUT*CNT_W-1:0]   occ
);
  localparam int CMAX = (1 << CNT_W) - 1;

  int hit_len [NUM_OUT];
  logic [NUM_OUT-1:0] hit;

  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) begin
      hit_len[i] = 0;
      hit[i]     = 1'b0;
      for (int k = 0; k < NUM_DEC; k++) begin
        if (grant_valid[k] && (int'(grant_port[k*PORT_W +: PORT_W]) == i)) begin
          hit[i]     = 1'b1;
          hit_len[i] = hit_len[i] + int'(req_len[k*LEN_W +: LEN_W]);
        end
      end
    end
  end

  function automatic int clamp_hi(input int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  for (genvar k = 0; k < NUM_DEC; k++) begin : g_req
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_int_n)
      grant_valid[k] |-> req_valid[k]);                                         // R9
    AST_GRANT_IN_MASK: assert property (@(posedge clk) disable iff (!rst_int_n)
      grant_valid[k] |-> req_cand[k*NUM_OUT + int'(grant_port[k*PORT_W +: PORT_W])]); // R2
    AST_EMPTY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_int_n)
      (req_cand[k*NUM_OUT +: NUM_OUT] == '0) |-> !grant_valid[k]);             // R9
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    AST_INC_EXACT: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!flit_leave[o] && hit[o]) |=>
        (int'(occ[o*CNT_W +: CNT_W]) ==
         clamp_hi(int'($past(occ[o*CNT_W +: CNT_W])) + $past(hit_len[o]))));    // R4
    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
      (flit_leave[o] && !hit[o] && (occ[o*CNT_W +: CNT_W] != '0)) |=>
        (int'(occ[o*CNT_W +: CNT_W]) == int'($past(occ[o*CNT_W +: CNT_W])) - 1)); // R5
    AST_BOTH_NET: assert property (@(posedge clk) disable iff (!rst_int_n)
      (flit_leave[o] && hit[o]) |=>
        (int'(occ[o*CNT_W +: CNT_W]) ==
         clamp_hi(((int'($past(occ[o*CNT_W +: CNT_W])) + $past(hit_len[o])) > 0) ?
                  (int'($past(occ[o*CNT_W +: CNT_W])) + $past(hit_len[o]) - 1) : 0))); // R6
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
      ((int'(occ[o*CNT_W +: CNT_W]) == CMAX) && !flit_leave[o]) |=>
        (int'(occ[o*CNT_W +: CNT_W]) == CMAX));                                 // R7
    AST_ZERO_FLOOR: assert property (@(posedge clk) disable iff (!rst_int_n)
      ((occ[o*CNT_W +: CNT_W] == '0) && !hit[o]) |=> (occ[o*CNT_W +: CNT_W] == '0)); // R8
  end
endmodule

bind occ_tracker occ_tracker_chk #(
  .NUM_OUT (NUM_OUT),
  .NUM_DEC (NUM_DEC),
  .CNT_W   (CNT_W),
  .LEN_W   (LEN_W),
  .PORT_W  (PORT_W)
) u_chk (.*);

// File: tb/occ_tracker_bench.sv
`timescale 1ns/1ps
module occ_tracker_bench;
  localparam int NO   = 5;
  localparam int ND   = 3;
  localparam int CW   = 5;
  localparam int LW   = 4;
  localparam int PW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic              clk;
  logic              rst_n;
  logic [ND-1:0]     req_valid;
  logic [ND*NO-1:0]  req_cand;
  logic [ND*LW-1:0]  req_len;
  logic [NO-1:0]     flit_leave;
  logic [ND-1:0]     grant_valid;
  logic [ND*PW-1:0]  grant_port;
  logic [NO*CW-1:0]  occ;

  int checks;
  int fails;
  bit done;
  int model [NO];

  occ_tracker #(.NUM_OUT(NO), .NUM_DEC(ND), .CNT_W(CW), .LEN_W(LW), .PORT_W(PW)) u_occ_tracker (
    .clk, .rst_n, .req_valid, .req_cand, .req_len, .flit_leave,
    .grant_valid, .grant_port, .occ
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL [%s] t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // Lowest load among candidates, ties to the lowest index; -1 when the mask is empty.
  function automatic int ref_pick(input int v [NO], input logic [NO-1:0] m);
    int best = -1;
    for (int i = 0; i < NO; i++)
      if (m[i] && (best < 0 || v[i] < v[best])) best = i;
    return best;
  endfunction

  task automatic run_cycle(input logic [ND-1:0] vld, input logic [ND*NO-1:0] cand,
                           input logic [ND*LW-1:0] len, input logic [NO-1:0] lv);
    int view [NO];
    int nxt  [NO];
    int inc  [NO];
    @(negedge clk);
    req_valid = vld; req_cand = cand; req_len = len; flit_leave = lv;
    #1;
    for (int i = 0; i < NO; i++) begin view[i] = model[i]; inc[i] = 0; end
    for (int k = 0; k < ND; k++) begin
      int p;
      p = vld[k] ? ref_pick(view, cand[k*NO +: NO]) : -1;
      check(grant_valid[k] == (p >= 0), (p < 0) ? "R9" : "R2",
            int'(grant_valid[k]), int'(p >= 0));
      if (p >= 0) begin
        check(int'(grant_port[k*PW +: PW]) == p, (k > 0) ? "R3" : "R2",
              int'(grant_port[k*PW +: PW]), p);
        view[p] += int'(len[k*LW +: LW]);
        inc[p]  += int'(len[k*LW +: LW]);
      end
    end
    for (int i = 0; i < NO; i++) begin
      nxt[i] = view[i];
      if (lv[i] && nxt[i] > 0) nxt[i]--;
      if (nxt[i] > CMAX) nxt[i] = CMAX;
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NO; i++) begin
      string tag;
      if (lv[i] && inc[i] > 0)      tag = "R6";
      else if (nxt[i] == CMAX && inc[i] > 0) tag = "R7";
      else if (lv[i] && model[i] == 0) tag = "R8";
      else if (inc[i] > 0)          tag = "R4";
      else if (lv[i])               tag = "R5";
      else                          tag = "R9";
      check(int'(occ[i*CW +: CW]) == nxt[i], tag, int'(occ[i*CW +: CW]), nxt[i]);
      model[i] = nxt[i];
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL [R1] watchdog expired: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [ND*NO-1:0] c;
    logic [ND*LW-1:0] l;
    logic [ND-1:0]    v;
    logic [NO-1:0]    lv;
    checks = 0; fails = 0; done = 0;
    void'($urandom(32'd1234));
    for (int i = 0; i < NO; i++) model[i] = 0;
    req_valid = '0; req_cand = '0; req_len = '0; flit_leave = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < NO; i++) check(occ[i*CW +: CW] == '0, "R1", int'(occ[i*CW +: CW]), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NO; i++) check(occ[i*CW +: CW] == '0, "R1", int'(occ[i*CW +: CW]), 0);

    // R8: departures on empty counters
    run_cycle('0, '0, '0, {NO{1'b1}});
    // R2: tie among candidates 1,2,4 -> output 1
    c = '0; c[0*NO +: NO] = 5'b10110; l = '0; l[0*LW +: LW] = 4'd3;
    run_cycle(3'b001, c, l, '0);
    // R3: three requests over all outputs spread to idle ones in order
    c = {3{5'b11111}}; l = {4'd2, 4'd2, 4'd2};
    run_cycle(3'b111, c, l, '0);
    // R9: invalid request with candidates, and valid request with empty mask
    c = '0; c[0*NO +: NO] = 5'b11111; l = {4'd5, 4'd5, 4'd5};
    run_cycle(3'b010, c, l, '0);
    // R6: grant and departure on the same output
    c = '0; c[0*NO +: NO] = 5'b00010; l = '0; l[0*LW +: LW] = 4'd4;
    run_cycle(3'b001, c, l, 5'b00010);
    // R5: plain departures
    run_cycle('0, '0, '0, 5'b00111);
    // R7: drive output 4 into saturation
    for (int n = 0; n < 4; n++) begin
      c = {3{5'b10000}}; l = {4'd15, 4'd15, 4'd15};
      run_cycle(3'b111, c, l, '0);
    end

    // Random phases: light, heavy, draining.
    for (int ph = 0; ph < 3; ph++) begin
      for (int n = 0; n < 1000; n++) begin
        v = ND'($urandom);
        c = (ND*NO)'($urandom);
        l = (ND*LW)'($urandom);
        lv = NO'($urandom);
        if (ph == 0) l = l & {ND{4'd3}};
        if (ph == 1) lv = lv & NO'($urandom);
        if (ph == 2) begin v = v & ND'($urandom) & ND'($urandom); lv = lv | NO'($urandom); end
        run_cycle(v, c, l, lv);
      end
    end

    done = 1;
    finish_run();
  end
endmodule